// File: doc/BRIEF.md
# Complementary PWM Driver with Dead-Time

This block turns one reference PWM waveform into a pair of gate-drive signals: a main output that is active while the reference is high, and a complementary output that is active while it is low. At every switching instant the output being turned off drops at once. The output being turned on waits a programmable number of clock cycles. This gap covers the turn-off delay of the external power switches and level shifters, so both switches are never on together.

The driver is steered by a master enable, one enable per output, two off-state selectors and two idle levels. The run-mode selector applies while the master enable is high and the idle-mode selector applies while it is low. Each output has its own polarity bit, applied at the pin. When the master enable drops, the pair moves to its idle levels through the same dead-time path. Each output has a drive-enable pin that tells the pad whether to drive or release it. A registered live flag reports whether the pair is in run mode.

Top module: `cpwm_deadtime`

## Requirements
- R1: While rst_n is low, main_oe_o, comp_oe_o and live_o are 0, and both outputs are inactive (with both polarity bits at 0, main_o and comp_o read 0).
- R2: When the state the inputs ask for makes an output inactive, that output goes inactive at the first clock edge that samples the request.
- R3: With the master enable high, both outputs enabled and a dead-time of N cycles, a reference edge takes the off-going output inactive at edge E0. The on-coming output goes active at edge E0+N. With N = 0 both outputs switch at E0.
- R4: A reference pulse that lasts fewer cycles than the dead-time never makes the delayed output active. The count restarts from the reference's return edge.
- R5: A polarity bit of 1 makes that pin active-low (pin = active XOR polarity). The polarity is applied combinationally after the delay.
- R6: With the master enable high and at most one output enabled, no dead-time is applied. An enabled output follows the reference one edge later. A disabled output is inactive. Its drive enable equals the run-mode off-state bit.
- R7: With the master enable low, the outputs move to their idle levels (1 = active). An output that becomes active still waits the dead-time. Both drive enables equal the idle-mode off-state bit.
- R8: If both idle levels request active, the complementary output is held inactive.
- R9: The main and complementary outputs are never active in the same cycle.
- R10: live_o is the master enable registered at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference PWM waveform |
| dt_i | input | DT_W | Dead-time in clock cycles |
| master_en_i | input | 1 | Master output enable |
| main_en_i | input | 1 | Main output enable |
| comp_en_i | input | 1 | Complementary output enable |
| main_pol_i | input | 1 | Main polarity, 1 = active-low |
| comp_pol_i | input | 1 | Complementary polarity, 1 = active-low |
| run_off_i | input | 1 | Run-mode off-state: drive disabled outputs inactive |
| idle_off_i | input | 1 | Idle-mode off-state: drive outputs at idle levels |
| main_idle_i | input | 1 | Main idle level, 1 = active |
| comp_idle_i | input | 1 | Complementary idle level, 1 = active |
| main_o | output | 1 | Main output pin level |
| comp_o | output | 1 | Complementary output pin level |
| main_oe_o | output | 1 | Main drive enable |
| comp_oe_o | output | 1 | Complementary drive enable |
| live_o | output | 1 | Registered master enable |

## Verification
A wrong dead-time count shows up at the pins as an on-coming edge that arrives early or late. The bench sees this at the exact edge the gap should close, at most N+1 cycles after the reference changes. A stale record of the requested state either swallows a later transition or replays one. Either way, the error appears on the next reference edge as a missing or spurious switch. Any fault that lets both switches turn on is caught in the very cycle it happens by the overlap watch on the polarity-corrected pins.

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  input  logic            master_en_i,
  input  logic            main_en_i,
  input  logic            comp_en_i,
  input  logic            main_pol_i,
  input  logic            comp_pol_i,
  input  logic            run_off_i,
  input  logic            idle_off_i,
  input  logic            main_idle_i,
  input  logic            comp_idle_i,
  output logic            main_o,
  output logic            comp_o,
  output logic            main_oe_o,
  output logic            comp_oe_o,
  output logic            live_o
);

  logic            both_en;
  logic [1:0]      want, want_q, act;
  logic [DT_W-1:0] eff_dt, cnt;
  logic            changed;

  assign both_en = main_en_i & comp_en_i;

  assign want[1] = master_en_i ? (main_en_i & ref_i)  : main_idle_i;
  assign want[0] = master_en_i ? (comp_en_i & ~ref_i) : (comp_idle_i & ~main_idle_i);

  assign eff_dt  = (master_en_i & ~both_en) ? '0 : dt_i;
  assign changed = (want != want_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q    <= '0;
      act       <= '0;
      cnt       <= '0;
      live_o    <= 1'b0;
      main_oe_o <= 1'b0;
      comp_oe_o <= 1'b0;
    end else begin
      live_o    <= master_en_i;
      main_oe_o <= master_en_i ? (main_en_i | run_off_i) : idle_off_i;
      comp_oe_o <= master_en_i ? (comp_en_i | run_off_i) : idle_off_i;
      want_q    <= want;
      if (changed) begin
        cnt <= eff_dt;
        act <= (eff_dt == '0) ? want : (act & want);
      end else if (cnt > 1) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= '0;
        act <= want_q;
      end
    end
  end

  assign main_o = act[1] ^ main_pol_i;
  assign comp_o = act[0] ^ comp_pol_i;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(act[1] && act[0])); // R9

  AST_ON_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(act[1]) || $rose(act[0])) |-> (cnt == '0)); // R3

  AST_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!want[1]) |=> !act[1]); // R2

  AST_RUN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en_i && run_off_i) |=> (main_oe_o && comp_oe_o)); // R6

  AST_IDLE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |=> (main_oe_o == idle_off_i) || !$stable(idle_off_i)); // R7

  AST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    master_en_i |=> live_o); // R10

endmodule

// File: tb/cpwm_deadtime_tb.sv
module cpwm_deadtime_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_i = 1'b0;
  logic [7:0] dt_i = 8'd4;
  logic       master_en_i = 1'b0, main_en_i = 1'b0, comp_en_i = 1'b0;
  logic       main_pol_i = 1'b0, comp_pol_i = 1'b0;
  logic       run_off_i = 1'b0, idle_off_i = 1'b0;
  logic       main_idle_i = 1'b0, comp_idle_i = 1'b0;
  logic       main_o, comp_o, main_oe_o, comp_oe_o, live_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [4:0] val;
    string      tag;
  } item_t;
  item_t sb[$];

  cpwm_deadtime #(.DT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dt_i(dt_i),
    .master_en_i(master_en_i), .main_en_i(main_en_i), .comp_en_i(comp_en_i),
    .main_pol_i(main_pol_i), .comp_pol_i(comp_pol_i),
    .run_off_i(run_off_i), .idle_off_i(idle_off_i),
    .main_idle_i(main_idle_i), .comp_idle_i(comp_idle_i),
    .main_o(main_o), .comp_o(comp_o), .main_oe_o(main_oe_o),
    .comp_oe_o(comp_oe_o), .live_o(live_o)
  );

  always #10ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] pins();
    return {main_o, comp_o, main_oe_o, comp_oe_o, live_o};
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic expect_at(int c, logic [4:0] v, string tag);
    item_t it;
    it.at = c; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2ns;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        if (sb[0].at < cyc) begin
          checks++; errors++;
          $display("FAIL %s: item for cycle %0d missed, got %b expected %b",
                   sb[0].tag, sb[0].at, pins(), sb[0].val);
        end else begin
          check(sb[0].tag, pins(), sb[0].val);
        end
        void'(sb.pop_front());
      end
      if ((main_o ^ main_pol_i) && (comp_o ^ comp_pol_i)) begin
        checks++; errors++;
        $display("FAIL R9 overlap at cycle %0d: got 11 expected not both active", cyc);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int k;
    tick(3);
    @(negedge clk);
    check("R1 reset state", pins(), 5'b00000);
    #1ns;
    rst_n = 1'b1;
    master_en_i = 1; main_en_i = 1; comp_en_i = 1; idle_off_i = 1;
    tick(10);
    k = cyc; expect_at(k + 1, 5'b01111, "R3 steady low");
    tick(3);

    // dead-time on rise and fall, N = 4
    ref_i = 1; k = cyc;
    expect_at(k + 1, 5'b00111, "R2 comp off at once");
    expect_at(k + 4, 5'b00111, "R3 gap still open");
    expect_at(k + 5, 5'b10111, "R3 main on after 4");
    tick(8);
    ref_i = 0; k = cyc;
    expect_at(k + 1, 5'b00111, "R2 main off at once");
    expect_at(k + 4, 5'b00111, "R3 gap still open");
    expect_at(k + 5, 5'b01111, "R3 comp on after 4");
    tick(8);

    // short pulse suppressed
    ref_i = 1; k = cyc;
    expect_at(k + 1, 5'b00111, "R4 comp off");
    tick(2);
    ref_i = 0;
    expect_at(k + 3, 5'b00111, "R4 main stays off");
    expect_at(k + 6, 5'b00111, "R4 count restarted");
    expect_at(k + 7, 5'b01111, "R4 comp back after 4");
    tick(10);

    // zero dead-time
    dt_i = 0; tick(2);
    ref_i = 1; k = cyc;
    expect_at(k + 1, 5'b10111, "R3 dt0 rise");
    tick(3);
    ref_i = 0; k = cyc;
    expect_at(k + 1, 5'b01111, "R3 dt0 fall");
    tick(3);

    // polarity
    ref_i = 1; tick(3);
    main_pol_i = 1; comp_pol_i = 1; k = cyc;
    expect_at(k, 5'b01111, "R5 active-low pins");
    tick(2);
    main_pol_i = 0; comp_pol_i = 0;
    tick(1);

    // single enable
    dt_i = 4; ref_i = 0; tick(10);
    comp_en_i = 0; run_off_i = 1; k = cyc;
    expect_at(k + 1, 5'b00111, "R6 disabled comp inactive");
    tick(3);
    ref_i = 1; k = cyc;
    expect_at(k + 1, 5'b10111, "R6 main no dead-time");
    tick(2);
    run_off_i = 0; k = cyc;
    expect_at(k + 1, 5'b10101, "R6 comp released");
    tick(3);

    // idle entry
    comp_en_i = 1; dt_i = 3; tick(3);
    master_en_i = 0; main_idle_i = 0; comp_idle_i = 1; idle_off_i = 1; k = cyc;
    expect_at(k + 1, 5'b00110, "R7 main off on idle entry");
    expect_at(k + 3, 5'b00110, "R7 idle dead-time");
    expect_at(k + 4, 5'b01110, "R7 comp idle active");
    tick(6);
    idle_off_i = 0; k = cyc;
    expect_at(k + 1, 5'b01000, "R7 released in idle");
    tick(3);
    idle_off_i = 1; main_idle_i = 1; k = cyc;
    expect_at(k + 1, 5'b00110, "R8 comp forced off");
    expect_at(k + 4, 5'b10110, "R8 only main active");
    tick(6);
    master_en_i = 1; k = cyc;
    expect_at(k + 1, 5'b10111, "R10 live back");
    tick(12);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1;
    finish_run();
  end
endmodule